// File: doc/BRIEF.md
# Receive Alarm Interrupt Register Bank

This block gathers eight single-cycle event pulses raised by the receive side of a DS3 framer: parity errors of two kinds, loss of signal, alarm indication, idle, far-end failure, application-identity change and out-of-frame. Each pulse is latched into a sticky status bit if its interrupt enable bit is set. The block raises an active-high interrupt request while any enabled status bit is pending.

Software reaches the block over a byte-wide register bus with an address, a read strobe, a write strobe, write data and registered read data. The enable register is read/write. The status register clears the bits it returned when it is read. A saturating 16-bit counter of P-bit parity error pulses is read as two bytes. Reading the high byte freezes the low byte, so the pair stays coherent, and reading the low byte restarts the count.

The bus is a plain strobe interface with no back-pressure. A strobe is accepted in the cycle it is high, and read data is valid in the following cycle. The event inputs are plain pulses with no handshake.

Top module: `rx_alarm_irq_bank`

## Requirements
- R1: After reset the enable register, the status register and the error counter are all 0, and `irq_o` is low.
- R2: The enable register is at address 0x12. A write stores `bus_wdata`, and a read returns the stored value. Bit order for both enable and status, from bit 7 down to bit 0: C-bit parity error, loss of signal, alarm indication, idle, far-end failure, identity change, out-of-frame, P-bit parity error. `evt_i[k]` maps to bit k.
- R3: A status bit becomes 1 only in the cycle after its `evt_i` bit is high while its enable bit is 1. A pulse arriving while the enable bit is 0 leaves the status bit at 0.
- R4: A read of address 0x13 returns the status register as it was before the read, then clears those bits. A write to 0x13 has no effect on the status register.
- R5: `irq_o` is high exactly when some bit is 1 in both status and enable. It falls in the cycle after the read that clears the last such bit.
- R6: An enabled event arriving in the same cycle as a status read leaves its status bit set after the read.
- R7: Every cycle with `evt_i[0]` high adds one to the error counter, whatever the enable bit holds. A read of 0x54 returns the counter's high byte and captures its low byte. A read of 0x55 returns the captured low byte.
- R8: The error counter holds at 0xFFFF once it reaches that value.
- R9: A read of 0x55 clears the error counter. If `evt_i[0]` is high in that same cycle, the counter becomes 1.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. A read of any unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Event pulses, one per alarm source |
| bus_addr | input | 8 | Register byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: eight sources, 8-bit address and data, and therefore a 16-bit counter. With these values the counter's saturation point is 65,535 pulses. A directed run holding the P-bit event high for just over that many cycles reaches it within the bench's cycle budget. Random phases interleave enable writes, status reads and counter reads with random event patterns. This puts reads that coincide with new events within reach often.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
  // Source positions inside the enable and status bytes
  typedef enum int unsigned {
    SRC_PBIT_ERR   = 0,
    SRC_OUT_FRAME  = 1,
    SRC_ID_CHANGE  = 2,
    SRC_FAR_FAIL   = 3,
    SRC_IDLE       = 4,
    SRC_ALARM_IND  = 5,
    SRC_SIG_LOSS   = 6,
    SRC_CBIT_ERR   = 7
  } src_idx_e;

  localparam logic [7:0] ADDR_ENABLE  = 8'h12;
  localparam logic [7:0] ADDR_STATUS  = 8'h13;
  localparam logic [7:0] ADDR_CNT_HI  = 8'h54;
  localparam logic [7:0] ADDR_CNT_LO  = 8'h55;

  // Decoded bus strobes
  typedef struct packed {
    logic wr_enable;
    logic rd_enable;
    logic rd_status;
    logic rd_cnt_hi;
    logic rd_cnt_lo;
    logic rd_any;
  } bus_dec_t;
endpackage

// File: rtl/rxirq_bus_dec.sv
module rxirq_bus_dec #(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] A_EN  = ADDR_W'(8'h12),
  parameter logic [ADDR_W-1:0] A_ST  = ADDR_W'(8'h13),
  parameter logic [ADDR_W-1:0] A_CHI = ADDR_W'(8'h54),
  parameter logic [ADDR_W-1:0] A_CLO = ADDR_W'(8'h55)
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd,
  input  logic                wr,
  output rxirq_pkg::bus_dec_t dec
);
  always_comb begin
    dec.wr_enable = wr && (addr == A_EN);
    dec.rd_enable = rd && (addr == A_EN);
    dec.rd_status = rd && (addr == A_ST);
    dec.rd_cnt_hi = rd && (addr == A_CHI);
    dec.rd_cnt_lo = rd && (addr == A_CLO);
    dec.rd_any    = rd;
  end
endmodule

// File: rtl/rxirq_evt_latch.sv
module rxirq_evt_latch #(
  parameter int unsigned SRC_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] evt,
  input  logic [SRC_N-1:0] en,
  input  logic             rd_clr,
  output logic [SRC_N-1:0] stat_q,
  output logic             irq
);
  logic [SRC_N-1:0] pend;

  for (genvar k = 0; k < SRC_N; k++) begin : g_bit
    // A read empties the bit, but an enabled event in the same cycle wins
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat_q[k] <= 1'b0;
      end else if (evt[k] && en[k]) begin
        stat_q[k] <= 1'b1;
      end else if (rd_clr) begin
        stat_q[k] <= 1'b0;
      end
    end
    assign pend[k] = stat_q[k] & en[k];
  end

  assign irq = |pend;
endmodule

// File: rtl/rxirq_err_cnt.sv
module rxirq_err_cnt #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              snap,
  input  logic              clr,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [BYTE_W-1:0] lo_snap_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= inc ? CNT_ONE : '0;
    end else if (inc && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_snap_q <= '0;
    end else if (snap) begin
      lo_snap_q <= cnt_q[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/rxirq_rd_mux.sv
module rxirq_rd_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rxirq_pkg::bus_dec_t dec,
  input  logic [DATA_W-1:0]   en_q,
  input  logic [DATA_W-1:0]   stat_q,
  input  logic [DATA_W-1:0]   cnt_hi,
  input  logic [DATA_W-1:0]   cnt_lo_snap,
  output logic [DATA_W-1:0]   rdata_q
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (dec.rd_enable) sel = en_q;
    if (dec.rd_status) sel = stat_q;
    if (dec.rd_cnt_hi) sel = cnt_hi;
    if (dec.rd_cnt_lo) sel = cnt_lo_snap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (dec.rd_any) begin
      rdata_q <= sel;
    end
  end
endmodule

// File: rtl/rx_alarm_irq_bank.sv
module rx_alarm_irq_bank #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SRC_N = DATA_W,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  import rxirq_pkg::*;

  bus_dec_t          dec;
  logic [SRC_N-1:0]  en_q;
  logic [SRC_N-1:0]  stat_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] lo_snap_q;

  rxirq_bus_dec #(
    .ADDR_W(ADDR_W),
    .A_EN  (ADDR_W'(ADDR_ENABLE)),
    .A_ST  (ADDR_W'(ADDR_STATUS)),
    .A_CHI (ADDR_W'(ADDR_CNT_HI)),
    .A_CLO (ADDR_W'(ADDR_CNT_LO))
  ) u_dec (
    .addr(bus_addr),
    .rd  (bus_rd),
    .wr  (bus_wr),
    .dec (dec)
  );

  // Enable register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (dec.wr_enable) begin
      en_q <= bus_wdata;
    end
  end

  rxirq_evt_latch #(.SRC_N(SRC_N)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt_i),
    .en    (en_q),
    .rd_clr(dec.rd_status),
    .stat_q(stat_q),
    .irq   (irq_o)
  );

  rxirq_err_cnt #(.BYTE_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (evt_i[SRC_PBIT_ERR]),
    .snap     (dec.rd_cnt_hi),
    .clr      (dec.rd_cnt_lo),
    .cnt_q    (cnt_q),
    .lo_snap_q(lo_snap_q)
  );

  rxirq_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec        (dec),
    .en_q       (en_q),
    .stat_q     (stat_q),
    .cnt_hi     (cnt_q[CNT_W-1:DATA_W]),
    .cnt_lo_snap(lo_snap_q),
    .rdata_q    (bus_rdata)
  );
endmodule

// File: rtl/rx_alarm_irq_bank_chk.sv
module rx_alarm_irq_bank_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] evt_i,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] en_q,
  input logic [DATA_W-1:0] stat_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              irq_o
);
  import rxirq_pkg::*;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic rd_st, rd_lo;
  assign rd_st = bus_rd && (bus_addr == ADDR_W'(ADDR_STATUS));
  assign rd_lo = bus_rd && (bus_addr == ADDR_W'(ADDR_CNT_LO));

  // R2: a write to the enable address is stored
  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(ADDR_ENABLE)) |=> (en_q == $past(bus_wdata)));

  // R3: newly set status bits must come from enabled events
  a_r3_no_masked_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_i & en_q)) == '0));

  // R4: a status read with no new events leaves status empty
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && evt_i == '0) |=> (stat_q == '0));

  // R5: interrupt only with something pending
  a_r5_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat_q != '0) && (en_q != '0));

  // R6: events coinciding with a status read survive it
  a_r6_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_st |=> ((stat_q & $past(evt_i & en_q)) == $past(evt_i & en_q)));

  // R8: counter holds at its ceiling
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !rd_lo) |=> (cnt_q == CMAX));

  // R9: low-byte read restarts the count
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !evt_i[0]) |=> (cnt_q == '0));
endmodule

bind rx_alarm_irq_bank rx_alarm_irq_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_i    (evt_i),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .en_q     (en_q),
  .stat_q   (stat_q),
  .cnt_q    (cnt_q),
  .irq_o    (irq_o)
);

// File: tb/rx_alarm_irq_bank_tb_top.sv
module rx_alarm_irq_bank_tb_top;
  localparam logic [7:0] A_EN = 8'h12, A_ST = 8'h13, A_HI = 8'h54, A_LO = 8'h55;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0, addr = '0, wdata = '0, rdata;
  logic       rd = 1'b0, wr = 1'b0, irq;

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  logic [7:0]  en_m = '0, st_m = '0, snap_m = '0, rd_m = '0;
  logic [15:0] cnt_m = '0;

  always #4 clk = ~clk;  // 125 MHz

  rx_alarm_irq_bank dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_addr(addr), .bus_rd(rd),
    .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  always @(posedge clk) n_cyc <= n_cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      A_EN:    return en_m;
      A_ST:    return st_m;
      A_HI:    return cnt_m[15:8];
      A_LO:    return snap_m;
      default: return 8'h00;
    endcase
  endfunction

  // One bus/event cycle, model advanced in step with the design
  task automatic cyc(input logic [7:0] ev, input logic r, input logic w,
                     input logic [7:0] a, input logic [7:0] wd, input bit chk_rd);
    logic [7:0] exp_rd;
    @(negedge clk);
    evt = ev; rd = r; wr = w; addr = a; wdata = wd;
    exp_rd = r ? exp_read(a) : rd_m;
    @(posedge clk); #1;
    if (r && a == A_HI) snap_m = cnt_m[7:0];
    if (r && a == A_LO) cnt_m = ev[0] ? 16'd1 : 16'd0;
    else if (ev[0] && cnt_m != 16'hFFFF) cnt_m = cnt_m + 16'd1;
    st_m = ((r && a == A_ST) ? 8'h00 : st_m) | (ev & en_m);
    if (w && a == A_EN) en_m = wd;
    rd_m = exp_rd;
    if (chk_rd) chk(rdata == exp_rd, "R10/R2/R4/R7 read data", rdata, exp_rd);
    chk(irq == |(st_m & en_m), "R5 irq level", irq, |(st_m & en_m));
    @(negedge clk);
    evt = '0; rd = 0; wr = 0;
  endtask

  initial begin : watchdog
    wait (n_cyc > 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_cyc, 190000);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_0017));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    cyc(8'h00, 1, 0, A_EN, 0, 0); chk(rdata == 8'h00, "R1 enable reset", rdata, 0);
    cyc(8'h00, 1, 0, A_ST, 0, 0); chk(rdata == 8'h00, "R1 status reset", rdata, 0);
    cyc(8'h00, 1, 0, A_HI, 0, 0); chk(rdata == 8'h00, "R1 counter reset", rdata, 0);

    // R3: event with enable 0 is not latched
    cyc(8'hFE, 0, 0, 0, 0, 0);
    cyc(8'h00, 1, 0, A_ST, 0, 0); chk(rdata == 8'h00, "R3 masked event", rdata, 0);

    // R2: enable write/read, bit 6 (loss of signal)
    cyc(8'h00, 0, 1, A_EN, 8'h40, 0);
    cyc(8'h00, 1, 0, A_EN, 0, 0); chk(rdata == 8'h40, "R2 enable readback", rdata, 8'h40);
    cyc(8'h40, 0, 0, 0, 0, 0); chk(irq == 1'b1, "R3 R5 enabled event raises irq", irq, 1);
    // R4: write to status ignored
    cyc(8'h00, 0, 1, A_ST, 8'h00, 0);
    cyc(8'h00, 0, 0, 0, 0, 0); chk(irq == 1'b1, "R4 status write ignored", irq, 1);
    // R4/R5: read returns then clears; irq falls next cycle
    cyc(8'h00, 1, 0, A_ST, 0, 0);
    chk(rdata == 8'h40, "R4 status read value", rdata, 8'h40);
    chk(irq == 1'b0, "R5 irq falls after clearing read", irq, 0);
    // R10: rdata holds, unmapped reads 0
    cyc(8'h00, 0, 0, 0, 0, 0); chk(rdata == 8'h40, "R10 rdata holds", rdata, 8'h40);
    cyc(8'h00, 1, 0, 8'h20, 0, 0); chk(rdata == 8'h00, "R10 unmapped read", rdata, 0);

    // R6: event in same cycle as status read survives
    cyc(8'h00, 0, 1, A_EN, 8'h81, 0);
    cyc(8'h80, 0, 0, 0, 0, 0);
    cyc(8'h01, 1, 0, A_ST, 0, 0); chk(rdata == 8'h80, "R6 read before coincident event", rdata, 8'h80);
    cyc(8'h00, 1, 0, A_ST, 0, 0); chk(rdata == 8'h01, "R6 coincident event kept", rdata, 8'h01);

    // R7/R9: counter pair and clear
    cyc(8'h00, 1, 0, A_HI, 0, 0);
    cyc(8'h00, 1, 0, A_LO, 0, 0);
    repeat (300) cyc(8'h01, 0, 0, 0, 0, 0);
    cyc(8'h01, 1, 0, A_HI, 0, 0); chk(rdata == 8'h01, "R7 high byte of 300", rdata, 8'h01);
    cyc(8'h00, 1, 0, A_LO, 0, 0); chk(rdata == 8'h2C, "R7 snapshot low byte", rdata, 8'h2C);
    cyc(8'h01, 1, 0, A_LO, 0, 0);
    cyc(8'h00, 1, 0, A_HI, 0, 0);
    cyc(8'h00, 1, 0, A_LO, 0, 0); chk(rdata == 8'h01, "R9 clear with coincident pulse", rdata, 1);

    // R8: saturation
    repeat (65600) cyc(8'h01, 0, 0, 0, 0, 0);
    cyc(8'h00, 1, 0, A_HI, 0, 0); chk(rdata == 8'hFF, "R8 saturated high", rdata, 8'hFF);
    cyc(8'h00, 1, 0, A_LO, 0, 0); chk(rdata == 8'hFF, "R8 saturated low", rdata, 8'hFF);
    cyc(8'h00, 1, 0, A_HI, 0, 0); chk(rdata == 8'h00, "R9 cleared after low read", rdata, 0);

    // Random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ev, a, wd;
      logic r, w;
      int sel;
      ev  = 8'($urandom) & 8'($urandom);
      sel = int'($urandom % 6);
      a   = (sel == 0) ? A_EN : (sel == 1) ? A_ST : (sel == 2) ? A_HI :
            (sel == 3) ? A_LO : (sel == 4) ? A_ST : 8'($urandom);
      r   = ($urandom % 3) == 0;
      w   = ($urandom % 5) == 0;
      wd  = 8'($urandom);
      cyc(ev, r, w, a, wd, r);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule